// File: doc/BRIEF.md
# Dual Backup Battery Status Monitor

This block sits beside a battery-backed memory controller. It works from digital comparator results: a per-battery "above 2.0 V" flag and a "battery A above battery B" flag. From these it follows which of two backup cells feeds the load while main power is absent. When main power drops, the higher cell is chosen. If that cell then fails while the other is still healthy, supply moves to the other cell and the block notes that a changeover took place.

When main power returns, the block makes one pass/fail decision on the batteries. If there was no changeover, only the cell in use at that moment is judged. If there was a changeover, both cells are judged, and either one being low is a failure. A failed decision is reported to software in one way only: the block silently blocks the second memory chip-enable cycle after power returns. A test routine can find this by reading a location, writing it, and reading it back.

A parameter selects single-cell use, in which battery B is never selected or judged. The synchroniser depth and the index of the blocked cycle are also parameters. The defaults are two stages and cycle 2.

Top module: `bat_status_mon`

## Requirements
- R1: On the first clock with power-good low after it was high, battery B is selected when the A-above-B flag is 0, and battery A is selected when it is 1.
- R2: During backup, if the selected battery's OK flag is 0 and the other battery's OK flag is 1, selection moves to the other battery and a changeover is recorded.
- R3: When power-good rises and no changeover was recorded, status is bad exactly when the OK flag of the battery selected at that moment is 0.
- R4: When power-good rises after a changeover, status is bad when either battery's OK flag is 0.
- R5: After power-good rises, each falling edge of the synchronised chip-enable input (`ce_ni`, active low) counts one cycle. Only cycle 2 is inhibited, and only when status is bad. Cycles 1, 3 and later are never inhibited.
- R6: When status is good, no chip-enable cycle is inhibited.
- R7: `ce_inhibit_o` rises at the third rising clock edge after `ce_ni` falls, and it falls at the third rising clock edge after `ce_ni` rises (default of two synchroniser stages).
- R8: The changeover record and the selection are cleared in the same clock that the status is captured. A later outage with no changeover therefore judges only the battery in use at that outage.
- R9: With `DUAL_BAT` = 0, battery B is never selected and its OK flag is ignored. Status is bad exactly when battery A's OK flag is 0.
- R10: Reset leaves `ce_inhibit_o` low, battery A selected, no changeover recorded and status good.
- R11: `ce_inhibit_o` is low from the first clock after power-good falls. Chip-enable edges during backup are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Main supply within tolerance (synchronous) |
| bat_a_ok_i | input | 1 | Battery A above 2.0 V |
| bat_b_ok_i | input | 1 | Battery B above 2.0 V |
| a_gt_b_i | input | 1 | Battery A voltage above battery B |
| ce_ni | input | 1 | Host memory chip enable, active low, asynchronous |
| ce_inhibit_o | output | 1 | Block the current chip-enable cycle |

## Verification
The hardest case to reach is a changeover after which the cell now in use is healthy but the abandoned one is still low. Only the both-cells rule flags this case, and it must be told apart from a later outage with no changeover, which must not inherit the old record. The stimulus gets there as follows. It enters backup with A higher, then drops A's OK flag while B stays good, and restores power with A still low. It then runs a second outage with B selected and A low but no changeover, and expects that outage to pass. A battery B that fails only on the edge where power returns checks that the decision uses the cell in use at that instant.

// File: rtl/bat_status_pkg.sv
package bat_status_pkg;
  typedef enum logic {BAT_A = 1'b0, BAT_B = 1'b1} bat_sel_e;

  function automatic logic status_bad(input logic switched, input bat_sel_e sel,
                                      input logic a_ok, input logic b_ok, input logic dual);
    if (switched) return !a_ok || (dual && !b_ok);
    if (sel == BAT_B) return !b_ok;
    return !a_ok;
  endfunction
endpackage

// File: rtl/bat_ce_sync.sv
module bat_ce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bat_select_trk.sv
module bat_select_trk
  import bat_status_pkg::*;
#(
  parameter bit DUAL_BAT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pwr_good_i,
  input  logic     pg_rise_i,
  input  logic     pg_fall_i,
  input  logic     bat_a_ok_i,
  input  logic     bat_b_ok_i,
  input  logic     a_gt_b_i,
  output bat_sel_e sel_o,
  output logic     switched_o
);
  bat_sel_e sel_q;
  logic     sw_q;

  generate
    if (DUAL_BAT) begin : g_dual
      logic cur_ok, oth_ok;
      assign cur_ok = (sel_q == BAT_A) ? bat_a_ok_i : bat_b_ok_i;
      assign oth_ok = (sel_q == BAT_A) ? bat_b_ok_i : bat_a_ok_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sel_q <= BAT_A;
          sw_q  <= 1'b0;
        end else if (pg_rise_i) begin
          sel_q <= BAT_A;
          sw_q  <= 1'b0;
        end else if (pg_fall_i) begin
          sel_q <= a_gt_b_i ? BAT_A : BAT_B;
        end else if (!pwr_good_i && !cur_ok && oth_ok) begin
          sel_q <= (sel_q == BAT_A) ? BAT_B : BAT_A;
          sw_q  <= 1'b1;
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sel_q <= BAT_A;
          sw_q  <= 1'b0;
        end else begin
          sel_q <= BAT_A;
          sw_q  <= 1'b0;
        end
      end
    end
  endgenerate

  assign sel_o      = sel_q;
  assign switched_o = sw_q;
endmodule

// File: rtl/bat_ce_gate.sv
module bat_ce_gate #(
  parameter int BLOCK_CYCLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic pg_rise_i,
  input  logic ce_s_i,
  input  logic bad_i,
  output logic inhibit_o
);
  localparam int CNT_W = $clog2(BLOCK_CYCLE + 1);
  localparam logic [CNT_W-1:0] HIT = CNT_W'(BLOCK_CYCLE - 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(BLOCK_CYCLE);

  logic             ce_q, blk_q, fall;
  logic [CNT_W-1:0] cnt_q;

  assign fall = ce_q & ~ce_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= 1'b1;
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      ce_q <= ce_s_i;
      if (pg_rise_i) begin
        cnt_q <= '0;
        blk_q <= 1'b0;
      end else if (!pwr_good_i) begin
        blk_q <= 1'b0;
      end else if (fall) begin
        if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == HIT && bad_i) blk_q <= 1'b1;
      end else if (ce_s_i) begin
        blk_q <= 1'b0;
      end
    end
  end

  assign inhibit_o = blk_q;
endmodule

// File: rtl/bat_status_mon.sv
module bat_status_mon
  import bat_status_pkg::*;
#(
  parameter bit DUAL_BAT    = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int BLOCK_CYCLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic bat_a_ok_i,
  input  logic bat_b_ok_i,
  input  logic a_gt_b_i,
  input  logic ce_ni,
  output logic ce_inhibit_o
);
  logic     pg_q, pg_rise, pg_fall, ce_s, switched, bad_q;
  bat_sel_e sel;

  assign pg_rise = pwr_good_i & ~pg_q;
  assign pg_fall = ~pwr_good_i & pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      pg_q <= pwr_good_i;
      if (pg_rise) bad_q <= status_bad(switched, sel, bat_a_ok_i, bat_b_ok_i, DUAL_BAT);
    end
  end

  bat_ce_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(ce_ni), .q_o(ce_s)
  );

  bat_select_trk #(.DUAL_BAT(DUAL_BAT)) u_sel (
    .clk_i, .rst_ni, .pwr_good_i, .pg_rise_i(pg_rise), .pg_fall_i(pg_fall),
    .bat_a_ok_i, .bat_b_ok_i, .a_gt_b_i, .sel_o(sel), .switched_o(switched)
  );

  bat_ce_gate #(.BLOCK_CYCLE(BLOCK_CYCLE)) u_gate (
    .clk_i, .rst_ni, .pwr_good_i, .pg_rise_i(pg_rise), .ce_s_i(ce_s),
    .bad_i(bad_q), .inhibit_o(ce_inhibit_o)
  );
endmodule

// File: rtl/bat_status_mon_sva.sv
module bat_status_mon_sva
  import bat_status_pkg::*;
#(
  parameter bit DUAL_BAT = 1'b1
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     pwr_good_i,
  input logic     ce_inhibit_o,
  input logic     ce_s,
  input logic     bad_q,
  input logic     switched,
  input bat_sel_e sel
);
  // R5 / R6: blocking only ever happens with a bad verdict
  a_r6_inhibit_needs_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_inhibit_o |-> bad_q);

  a_r11_inhibit_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_inhibit_o |-> $past(pwr_good_i));

  a_r8_clear_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_good_i) |=> (!switched && sel == BAT_A));

  a_r2_switch_only_backup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switched |-> !$past(pwr_good_i));

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_s) |=> !ce_inhibit_o);

  generate
    if (!DUAL_BAT) begin : g_single
      a_r9_single_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel == BAT_A && !switched);
    end
  endgenerate
endmodule

bind bat_status_mon bat_status_mon_sva #(.DUAL_BAT(DUAL_BAT)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .ce_inhibit_o(ce_inhibit_o),
  .ce_s(ce_s), .bad_q(bad_q), .switched(switched), .sel(sel)
);

// File: tb/tb_bat_status_mon.sv
module tb_bat_status_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b1, a_ok = 1'b1, b_ok = 1'b1, gt = 1'b1, ce = 1'b1;
  logic inh_d, inh_s;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  bat_status_mon #(.DUAL_BAT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .bat_a_ok_i(a_ok), .bat_b_ok_i(b_ok),
    .a_gt_b_i(gt), .ce_ni(ce), .ce_inhibit_o(inh_d)
  );

  bat_status_mon #(.DUAL_BAT(1'b0)) dut_single (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .bat_a_ok_i(a_ok), .bat_b_ok_i(b_ok),
    .a_gt_b_i(gt), .ce_ni(ce), .ce_inhibit_o(inh_s)
  );

  // behavioural reference: index 0 dual, index 1 single
  int m_sel[2], m_sw[2], m_bad[2], m_cnt[2], m_blk[2], m_pgq[2];
  int m_c1[2], m_c2[2], m_c3[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_sel[i] = 0; m_sw[i] = 0; m_bad[i] = 0; m_cnt[i] = 0; m_blk[i] = 0;
        m_pgq[i] = 0; m_c1[i] = 1; m_c2[i] = 1; m_c3[i] = 1;
      end else begin
        int dual;
        int fall, up, down, old_bad;
        dual = (i == 0);
        fall = (m_c3[i] == 1 && m_c2[i] == 0);
        up = (pg && m_pgq[i] == 0);
        down = (!pg && m_pgq[i] == 1);
        old_bad = m_bad[i];
        if (up) begin
          if (m_sw[i] != 0) m_bad[i] = (!a_ok || (dual != 0 && !b_ok));
          else if (m_sel[i] != 0) m_bad[i] = !b_ok;
          else m_bad[i] = !a_ok;
          m_sw[i] = 0; m_sel[i] = 0;
        end else if (down) begin
          m_sel[i] = (dual != 0 && !gt) ? 1 : 0;
        end else if (!pg && dual != 0) begin
          if (m_sel[i] == 0 && !a_ok && b_ok) begin m_sel[i] = 1; m_sw[i] = 1; end
          else if (m_sel[i] == 1 && !b_ok && a_ok) begin m_sel[i] = 0; m_sw[i] = 1; end
        end
        if (up) begin
          m_cnt[i] = 0; m_blk[i] = 0;
        end else if (!pg) begin
          m_blk[i] = 0;
        end else if (fall) begin
          if (m_cnt[i] == 1 && old_bad != 0) m_blk[i] = 1;
          if (m_cnt[i] < 2) m_cnt[i]++;
        end else if (m_c2[i] == 1) begin
          m_blk[i] = 0;
        end
        m_c3[i] = m_c2[i]; m_c2[i] = m_c1[i]; m_c1[i] = ce;
        m_pgq[i] = pg;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(inh_d, logic'(m_blk[0] != 0), cur_req, "model compare dual");
      chk(inh_s, logic'(m_blk[1] != 0), cur_req, "model compare single");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one chip-enable cycle with hand-derived expectations (R7 timing)
  task automatic pulse(input logic exp_d, input logic exp_s, input string tag);
    ce = 1'b0;
    cyc(2); chk(inh_d, 1'b0, tag, "before third edge");
    cyc(1); chk(inh_d, exp_d, tag, "dual inhibit"); chk(inh_s, exp_s, tag, "single inhibit");
    cyc(3); ce = 1'b1;
    cyc(2); chk(inh_d, exp_d, "R7", "held until third edge");
    cyc(1); chk(inh_d, 1'b0, "R7", "released"); chk(inh_s, 1'b0, "R7", "single released");
    cyc(3);
  endtask

  initial begin
    cyc(4); rst_n = 1'b1;
    cyc(1); chk(inh_d, 1'b0, "R10", "reset state"); chk(inh_s, 1'b0, "R10", "reset state");
    cyc(3);

    cur_req = "R6";
    pulse(0, 0, "R6"); pulse(0, 0, "R6"); pulse(0, 0, "R6");

    // R3: A selected and good, B low: good
    cur_req = "R3";
    gt = 1'b1; b_ok = 1'b0; pg = 1'b0; cyc(4);
    pg = 1'b1; cyc(4);
    pulse(0, 0, "R3"); pulse(0, 0, "R3");

    // R1/R3/R9: B selected; B fails on the return edge
    cur_req = "R1";
    b_ok = 1'b1; gt = 1'b0; pg = 1'b0; cyc(4);
    b_ok = 1'b0; pg = 1'b1; cyc(4);
    pulse(0, 0, "R5"); pulse(1, 0, "R1"); pulse(0, 0, "R5"); pulse(0, 0, "R9");

    // R2/R4: A selected, fails in backup, changeover to B; A still low on return
    cur_req = "R4";
    a_ok = 1'b1; b_ok = 1'b1; gt = 1'b1; pg = 1'b0; cyc(4);
    a_ok = 1'b0; cyc(4);
    pulse(0, 0, "R11");
    pg = 1'b1; cyc(4);
    pulse(0, 0, "R4"); pulse(1, 1, "R2"); pulse(0, 0, "R5");

    // R8: B selected, A low, no changeover: only B judged
    cur_req = "R8";
    a_ok = 1'b1; gt = 1'b0; pg = 1'b0; cyc(4);
    a_ok = 1'b0; cyc(4);
    pg = 1'b1; cyc(4);
    pulse(0, 0, "R8"); pulse(0, 1, "R8");

    // R11: power lost in the middle of the blocked cycle
    cur_req = "R11";
    a_ok = 1'b1; b_ok = 1'b1; gt = 1'b0; pg = 1'b0; cyc(4);
    b_ok = 1'b0; pg = 1'b1; cyc(4);
    pulse(0, 0, "R11");
    ce = 1'b0; cyc(3); chk(inh_d, 1'b1, "R11", "cycle 2 blocked");
    pg = 1'b0; cyc(1); chk(inh_d, 1'b0, "R11", "dropped after power loss");
    ce = 1'b1; cyc(4);
    b_ok = 1'b1; pg = 1'b1; cyc(4);
    pulse(0, 0, "R6"); pulse(0, 0, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule